// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block sits between a serial deserializer and the register interface of a UART receiver. It keeps up to four received bytes in arrival order and gives the host one byte for each read strobe. It drives three flags from its fill level: a ready flag when at least one byte is waiting, a full flag when every slot is taken, and an accept flag that the deserializer uses for flow control.

A line-break event is handled like a received byte with the value zero. It also latches a break-change flag for the interrupt logic. A break is never lost. If the queue is already full, the zero overwrites the most recently stored byte. A normal byte that arrives at a full queue is thrown away, and the block pulses an overrun indication.

A receiver-reset command empties the queue and turns the receiver off. Separate commands turn the receiver on and off. A read of an empty queue and a read that coincides with an arriving byte both have fixed, defined outcomes.

Top module: `rx_hold_fifo`

## Requirements
- R1: After `rst`, `rx_ready`, `fifo_full`, `can_accept`, `brk_pending` and `overrun` are 0, `rd_data` is 0x00, and the receiver is disabled.
- R2: The queue holds four bytes and returns them oldest first. `fifo_full` becomes 1 in the cycle after the fourth byte is stored. `can_accept` equals receiver-enabled and not `fifo_full`.
- R3: Storing any byte, whether data or break, makes `rx_ready` 1 in the next cycle. `rx_ready` returns to 0 in the cycle after the last stored byte is read.
- R4: A `host_rd` pulse on a non-empty queue puts the oldest byte on `rd_data` in the next cycle, moves the remaining bytes forward and clears `fifo_full`.
- R5: A `host_rd` pulse on an empty queue leaves `rd_data` at the last value read and leaves all flags unchanged.
- R6: When `host_rd` and an accepted `rx_valid` fall in the same cycle, the read is done first and then the push. The fill level is unchanged, and this holds even when the queue is full.
- R7: A data byte offered while the queue is full, with no read in the same cycle, is discarded. `overrun` is 1 for exactly one cycle, the cycle after. A byte offered while the receiver is disabled is discarded without `overrun`.
- R8: `rx_break` sets `brk_pending` in the next cycle and stores a 0x00 byte, even while the receiver is disabled. If `rx_valid` is high in the same cycle, that data byte is ignored.
- R9: A break at a full queue replaces the newest stored byte with 0x00, and `fifo_full` stays 1.
- R10: `brk_pending` holds until `brk_ack`. If `rx_break` and `brk_ack` arrive together, the flag stays set.
- R11: `rcv_reset` empties the queue, clears `rx_ready` and `fifo_full`, and disables the receiver. It takes priority over a read or push in the same cycle, and `rd_data` keeps its value.
- R12: `rcv_enable` enables the receiver and `rcv_disable` disables it. When both are high, disable wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received data byte strobe |
| rx_data | input | 8 | Received data byte |
| rx_break | input | 1 | Line-break event strobe |
| host_rd | input | 1 | Host read of the receive buffer |
| rcv_enable | input | 1 | Receiver enable command |
| rcv_disable | input | 1 | Receiver disable command |
| rcv_reset | input | 1 | Receiver reset command |
| brk_ack | input | 1 | Clears the break-change flag |
| rd_data | output | 8 | Byte returned by the last effective read |
| rx_ready | output | 1 | At least one byte waiting |
| fifo_full | output | 1 | All four slots occupied |
| can_accept | output | 1 | Receiver enabled and queue not full |
| brk_pending | output | 1 | Break-change flag toward interrupt logic |
| overrun | output | 1 | One-cycle pulse for a dropped data byte |

## Verification
The bench sweeps every starting fill level from zero to four. At each level it tries three patterns: a plain fill followed by a drain, a read and a push in the same cycle, and a break. The fill sweep shows that ordering and the full threshold are right. The same-cycle pattern at level four separates read-then-push ordering from push-then-read, which would drop the byte. The break sweep at level four separates overwriting the newest byte from dropping the break or overwriting the oldest byte. Further patterns cover an empty read, a full-queue overrun, input while disabled, a break together with data, and a receiver reset together with a read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH = 4;
    localparam int unsigned RXQ_WIDTH = 8;

    // Per-cycle decision handed from the controller to storage and flags
    typedef struct packed {
        logic pop;   // oldest entry leaves, the rest move forward
        logic wr;    // one slot is written after the move
        logic drop;  // a data byte was refused at a full queue
    } rxq_plan_t;

    function automatic int unsigned rxq_lvl_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_WIDTH,
    localparam int unsigned LW = rxq_lvl_bits(DEPTH)
) (
    input  logic [LW-1:0]    level,
    input  logic             enabled,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_brk,
    input  logic             host_rd,
    input  logic             rcv_reset,
    output rxq_plan_t        plan,
    output logic [LW-1:0]    widx,
    output logic [WIDTH-1:0] wdata,
    output logic [LW-1:0]    level_nx
);

    localparam logic [LW-1:0] LVL_TOP  = LW'(DEPTH);
    localparam logic [LW-1:0] LVL_LAST = LW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_ONE  = LW'(1);

    logic [LW-1:0] lvl_after;

    always_comb begin
        plan      = '0;
        widx      = '0;
        wdata     = '0;
        lvl_after = level;
        if (!rcv_reset && host_rd && (level != '0)) begin
            plan.pop  = 1'b1;
            lvl_after = level - LVL_ONE;
        end
        level_nx = lvl_after;

        if (rcv_reset) begin
            level_nx = '0;
        end else if (in_brk) begin
            plan.wr = 1'b1;
            wdata   = '0;
            if (lvl_after == LVL_TOP) begin
                widx = LVL_LAST;
            end else begin
                widx     = lvl_after;
                level_nx = lvl_after + LVL_ONE;
            end
        end else if (in_valid && enabled) begin
            if (lvl_after < LVL_TOP) begin
                plan.wr  = 1'b1;
                widx     = lvl_after;
                wdata    = in_data;
                level_nx = lvl_after + LVL_ONE;
            end else begin
                plan.drop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_WIDTH,
    localparam int unsigned LW = rxq_lvl_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             wr,
    input  logic [LW-1:0]    widx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head
);

    logic [WIDTH-1:0] slot_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] q;
        logic [WIDTH-1:0] moved;
        logic [WIDTH-1:0] nx;

        if (i == DEPTH - 1) begin : g_tail
            assign moved = q;
        end else begin : g_body
            assign moved = pop ? slot_w[i+1] : q;
        end

        assign nx = (wr && (widx == LW'(i))) ? wdata : moved;

        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= nx;
        end

        assign slot_w[i] = q;
    end

    assign head = slot_w[0];

endmodule

// File: rtl/rxq_state.sv
module rxq_state (
    input  logic clk,
    input  logic rst,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic rcv_reset,
    input  logic brk_evt,
    input  logic brk_ack,
    input  logic drop,
    output logic enabled,
    output logic brk_flag,
    output logic ovr_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled   <= 1'b0;
            brk_flag  <= 1'b0;
            ovr_pulse <= 1'b0;
        end else begin
            if (rcv_reset || dis_cmd) enabled <= 1'b0;
            else if (en_cmd)          enabled <= 1'b1;

            if (brk_evt)      brk_flag <= 1'b1;
            else if (brk_ack) brk_flag <= 1'b0;

            ovr_pulse <= drop;
        end
    end

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [WIDTH-1:0] rx_data,
    input  logic             rx_break,
    input  logic             host_rd,
    input  logic             rcv_enable,
    input  logic             rcv_disable,
    input  logic             rcv_reset,
    input  logic             brk_ack,
    output logic [WIDTH-1:0] rd_data,
    output logic             rx_ready,
    output logic             fifo_full,
    output logic             can_accept,
    output logic             brk_pending,
    output logic             overrun
);

    localparam int unsigned LW = rxq_lvl_bits(DEPTH);

    logic [LW-1:0]    level_q;
    logic [LW-1:0]    level_nx;
    logic [LW-1:0]    widx;
    logic [WIDTH-1:0] wdata;
    logic [WIDTH-1:0] head;
    logic             enabled;
    rxq_plan_t        plan;

    rxq_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
        .level     (level_q),
        .enabled   (enabled),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .in_brk    (rx_break),
        .host_rd   (host_rd),
        .rcv_reset (rcv_reset),
        .plan      (plan),
        .widx      (widx),
        .wdata     (wdata),
        .level_nx  (level_nx)
    );

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .pop   (plan.pop),
        .wr    (plan.wr),
        .widx  (widx),
        .wdata (wdata),
        .head  (head)
    );

    rxq_state u_state (
        .clk       (clk),
        .rst       (rst),
        .en_cmd    (rcv_enable),
        .dis_cmd   (rcv_disable),
        .rcv_reset (rcv_reset),
        .brk_evt   (rx_break),
        .brk_ack   (brk_ack),
        .drop      (plan.drop),
        .enabled   (enabled),
        .brk_flag  (brk_pending),
        .ovr_pulse (overrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            rd_data <= '0;
        end else begin
            level_q <= level_nx;
            if (plan.pop) rd_data <= head;
        end
    end

    assign rx_ready   = (level_q != '0);
    assign fifo_full  = (level_q == LW'(DEPTH));
    assign can_accept = enabled && !fifo_full;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_break,
    input logic             host_rd,
    input logic             rcv_disable,
    input logic             rcv_reset,
    input logic             brk_ack,
    input logic [WIDTH-1:0] rd_data,
    input logic             rx_ready,
    input logic             fifo_full,
    input logic             can_accept,
    input logic             brk_pending,
    input logic             overrun
);

    // R11
    rcv_reset_empties_chk: assert property (@(posedge clk) disable iff (rst)
        rcv_reset |=> (!rx_ready && !fifo_full && !can_accept));

    // R5
    empty_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !rx_ready && !rcv_reset && !rx_valid && !rx_break) |=> ($stable(rd_data) && !rx_ready));

    // R8
    break_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rx_break |=> brk_pending);

    // R10
    break_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_pending && !brk_ack) |=> brk_pending);

    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(rx_valid && fifo_full && !host_rd && !rx_break && !rcv_reset));

    // R9
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !host_rd && !rcv_reset) |=> fifo_full);

    // R3
    ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !host_rd && !rcv_reset) |=> rx_ready);

    // R12
    disable_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        rcv_disable |=> !can_accept);

endmodule

bind rx_hold_fifo rxq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_break    (rx_break),
    .host_rd     (host_rd),
    .rcv_disable (rcv_disable),
    .rcv_reset   (rcv_reset),
    .brk_ack     (brk_ack),
    .rd_data     (rd_data),
    .rx_ready    (rx_ready),
    .fifo_full   (fifo_full),
    .can_accept  (can_accept),
    .brk_pending (brk_pending),
    .overrun     (overrun)
);

// File: tb/sim_rx_hold_fifo.sv
module sim_rx_hold_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_break = 1'b0;
    logic       host_rd = 1'b0;
    logic       rcv_enable = 1'b0;
    logic       rcv_disable = 1'b0;
    logic       rcv_reset = 1'b0;
    logic       brk_ack = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready, fifo_full, can_accept, brk_pending, overrun;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] mq[$];
    logic [7:0] last_rd;

    always #4 clk = ~clk;

    rx_hold_fifo u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .host_rd(host_rd), .rcv_enable(rcv_enable),
        .rcv_disable(rcv_disable), .rcv_reset(rcv_reset), .brk_ack(brk_ack),
        .rd_data(rd_data), .rx_ready(rx_ready), .fifo_full(fifo_full),
        .can_accept(can_accept), .brk_pending(brk_pending), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        rx_valid = 0; rx_break = 0; host_rd = 0; rcv_enable = 0;
        rcv_disable = 0; rcv_reset = 0; brk_ack = 0;
    endtask

    task automatic push(input logic [7:0] d);
        rx_valid = 1; rx_data = d; tick();
        if (mq.size() < 4) mq.push_back(d);
    endtask

    task automatic drain(input string req);
        while (mq.size() > 0) begin
            host_rd = 1; tick();
            chk(req, rd_data, mq[0]);
            chk({req, " full clears on read"}, {7'd0, fifo_full}, 8'd0);
            last_rd = mq.pop_front();
        end
        chk({req, " ready clears at empty"}, {7'd0, rx_ready}, 8'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2; tick(); tick(); rst = 0;
        // R1 reset state
        chk("R1 ready", {7'd0, rx_ready}, 8'd0);
        chk("R1 full", {7'd0, fifo_full}, 8'd0);
        chk("R1 accept", {7'd0, can_accept}, 8'd0);
        chk("R1 brk", {7'd0, brk_pending}, 8'd0);
        chk("R1 overrun", {7'd0, overrun}, 8'd0);
        chk("R1 rd_data", rd_data, 8'h00);

        // R12 enable / disable, disable wins
        rcv_enable = 1; rcv_disable = 1; tick();
        chk("R12 both -> disabled", {7'd0, can_accept}, 8'd0);
        rcv_enable = 1; tick();
        chk("R12 enable", {7'd0, can_accept}, 8'd1);

        // R2 R3 R4 fill sweep over levels 1..4
        for (int n = 1; n <= 4; n++) begin
            for (int k = 0; k < n; k++) begin
                push(8'(8'h10 * n + k + 1));
                chk("R3 ready after push", {7'd0, rx_ready}, 8'd1);
                chk("R2 full at fourth", {7'd0, fifo_full}, {7'd0, (k + 1 == 4)});
                chk("R2 accept", {7'd0, can_accept}, {7'd0, (k + 1 != 4)});
            end
            drain("R4 oldest first");
        end

        // R5 read on empty
        host_rd = 1; tick();
        chk("R5 rd_data kept", rd_data, last_rd);
        chk("R5 ready stays 0", {7'd0, rx_ready}, 8'd0);
        chk("R5 full stays 0", {7'd0, fifo_full}, 8'd0);

        // R7 overrun at full
        for (int k = 0; k < 4; k++) push(8'(8'h60 + k));
        rx_valid = 1; rx_data = 8'h5A; tick();
        chk("R7 overrun pulse", {7'd0, overrun}, 8'd1);
        tick();
        chk("R7 overrun one cycle", {7'd0, overrun}, 8'd0);
        drain("R7 dropped byte absent");

        // R7 disabled: dropped without overrun
        rcv_disable = 1; tick();
        rx_valid = 1; rx_data = 8'h77; tick();
        tick();
        chk("R7 disabled no store", {7'd0, rx_ready}, 8'd0);
        chk("R7 disabled no overrun", {7'd0, overrun}, 8'd0);
        rcv_enable = 1; tick();

        // R6 simultaneous read and push at levels 1..4
        for (int n = 1; n <= 4; n++) begin
            for (int k = 0; k < n; k++) push(8'(8'h80 + 8'h10 * n + k));
            host_rd = 1; rx_valid = 1; rx_data = 8'hC0 + 8'(n); tick();
            chk("R6 read first", rd_data, mq[0]);
            last_rd = mq.pop_front();
            mq.push_back(8'hC0 + 8'(n));
            chk("R6 level kept (full)", {7'd0, fifo_full}, {7'd0, (n == 4)});
            chk("R6 no overrun", {7'd0, overrun}, 8'd0);
            drain("R6 order after combined");
        end

        // R8 R9 R10 break sweep at levels 0..4
        for (int n = 0; n <= 4; n++) begin
            for (int k = 0; k < n; k++) push(8'(8'h30 + 8'h10 * n + k));
            rx_break = 1; tick();
            if (mq.size() == 4) mq[3] = 8'h00; else mq.push_back(8'h00);
            chk("R8 brk flag set", {7'd0, brk_pending}, 8'd1);
            chk("R3 ready after break", {7'd0, rx_ready}, 8'd1);
            chk("R9 full after break", {7'd0, fifo_full}, {7'd0, (n >= 3)});
            drain("R9 break byte placement");
            chk("R10 held", {7'd0, brk_pending}, 8'd1);
            rx_break = 1; brk_ack = 1; tick();
            chk("R10 set wins over ack", {7'd0, brk_pending}, 8'd1);
            mq.push_back(8'h00);
            drain("R8 break byte");
            brk_ack = 1; tick();
            chk("R10 ack clears", {7'd0, brk_pending}, 8'd0);
        end

        // R8 break beats data; break accepted while disabled
        rx_break = 1; rx_valid = 1; rx_data = 8'hEE; tick();
        mq.push_back(8'h00);
        drain("R8 data ignored with break");
        rcv_disable = 1; tick();
        rx_break = 1; tick();
        chk("R8 break while disabled stored", {7'd0, rx_ready}, 8'd1);
        mq.push_back(8'h00);
        drain("R8 disabled break byte");
        rcv_enable = 1; brk_ack = 1; tick();

        // R11 receiver reset beats read and push
        for (int k = 0; k < 3; k++) push(8'(8'hD0 + k));
        host_rd = 1; rx_valid = 1; rx_data = 8'h99; rcv_reset = 1; tick();
        mq.delete();
        chk("R11 ready clear", {7'd0, rx_ready}, 8'd0);
        chk("R11 full clear", {7'd0, fifo_full}, 8'd0);
        chk("R11 disabled", {7'd0, can_accept}, 8'd0);
        chk("R11 rd_data kept", rd_data, last_rd);
        rx_valid = 1; rx_data = 8'h42; tick();
        chk("R11 stays disabled", {7'd0, rx_ready}, 8'd0);
        rcv_enable = 1; tick();
        push(8'h42);
        drain("R11 fresh after reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule